// File: doc/BRIEF.md
# Multi-frame video CRC checker

This block watches a received digital video stream and tells whether a supposedly static picture really is identical from frame to frame. On the pixel clock it takes a vertical sync, a data-enable and three 8-bit colour components. For each colour channel it computes a 16-bit CRC over that channel's active pixels in one frame. The generator polynomial is x^16 + x^12 + x^5 + 1. The CRC restarts at every frame boundary.

A host writes a control word made of an enable bit and a frame count. Once armed, the block waits for a vertical sync, so that it never analyses a frame it joined part way through. It then analyses the programmed number of whole frames without any further host action. The checksum of the first analysed frame becomes the reference for each channel. Every later frame is compared with that reference, and any difference sets a sticky per-channel mismatch flag. The latest per-frame checksums, the index of the frame they belong to, a done flag and the mismatch flags stay on the outputs for the host to read.

Top module: `vcrc_frame_checker`

## Requirements
- R1: The checksum of a channel for one frame is the CRC-16 with polynomial 0x1021, preset to 0xFFFF at the vertical sync rising edge that opens the frame. Each 8-bit component sampled with `de_i` high is folded in, most significant bit first, and nothing else is folded in. A frame ends at the next rising edge of `vsync_i`.
- R2: Red, green and blue are checked independently, each with its own checksum output. `mism_o` bit 0 is red, bit 1 is green and bit 2 is blue.
- R3: After arming, pixels seen before the first rising edge of `vsync_i` are ignored, and the first analysed frame begins at that edge.
- R4: `ctl_frames_i` selects 1 to 255 frames, and the value 0 is treated as 1. The cycle after each analysed frame ends, `frm_vld_o` pulses for one cycle and `frm_idx_o` gives the number of frames completed (1-based). `done_o` rises in the same cycle that the last frame's pulse appears.
- R5: The first analysed frame's checksums become the reference. A later frame whose checksum differs on a channel sets that channel's mismatch bit, and the bit stays set until the next start write. A static input leaves all bits clear.
- R6: Flipping a single bit of a single pixel in one frame changes that frame's checksum on the affected channel only.
- R7: A control write with the enable bit set restarts the analysis. In the next cycle `done_o` and `mism_o` are 0, `busy_o` is 1 and `frm_idx_o` is 0.
- R8: A control write with the enable bit clear aborts the run. In the next cycle `busy_o` and `done_o` are 0, and later frames produce no `frm_vld_o` pulses.
- R9: While `done_o` is high and no control write arrives, the checksum outputs, `mism_o` and `done_o` stay unchanged whatever video arrives.
- R10: After reset, `busy_o`, `done_o`, `frm_vld_o`, `mism_o`, `frm_idx_o` and all checksum outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vsync_i | input | 1 | Vertical sync, active high; its rising edge is a frame boundary |
| de_i | input | 1 | Data enable; high marks an active pixel |
| pix_r_i | input | 8 | Red component |
| pix_g_i | input | 8 | Green component |
| pix_b_i | input | 8 | Blue component |
| ctl_wr_i | input | 1 | Control write strobe, one cycle |
| ctl_en_i | input | 1 | Enable bit of the control write (1 start, 0 abort) |
| ctl_frames_i | input | 8 | Number of frames to analyse, captured on a start write |
| busy_o | output | 1 | Armed or analysing |
| done_o | output | 1 | Programmed number of frames analysed |
| frm_vld_o | output | 1 | One-cycle pulse: new per-frame checksums present |
| frm_idx_o | output | 8 | Frames completed in the current run |
| crc_r_o | output | 16 | Red checksum of the last completed frame |
| crc_g_o | output | 16 | Green checksum of the last completed frame |
| crc_b_o | output | 16 | Blue checksum of the last completed frame |
| mism_o | output | 3 | Sticky per-channel mismatch flags |

## Verification
The bench builds the block with its default parameters: 8-bit components, a 16-bit CRC and an 8-bit frame counter. With these, a run of 255 frames drives the counter to the top of its range, and the value 0 exercises the lower edge. The frames are kept to 16x4 active pixels with blanking, which makes long runs, an arm in the middle of a frame, an abort, and a single flipped bit in a middle frame all cheap to drive. A bit-serial reference model checks every recorded checksum.

// File: rtl/vcrc_pkg.sv
package vcrc_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ARM  = 2'd1,
    S_RUN  = 2'd2,
    S_DONE = 2'd3
  } vcrc_state_e;

  // Per-frame control shared by every channel lane
  typedef struct packed {
    logic clear;   // start write: drop the mismatch flags
    logic start;   // frame boundary: preset the running CRC
    logic open;    // a frame is being analysed
    logic close;   // the frame being analysed has ended
    logic first;   // the frame that is closing is the reference frame
  } vcrc_lane_ctl_t;

endpackage

// File: rtl/vcrc_rst_sync.sv
module vcrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vcrc_seq.sv
module vcrc_seq
  import vcrc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync_i,
  input  logic                 ctl_wr_i,
  input  logic                 ctl_en_i,
  input  logic [CNT_W-1:0]     ctl_frames_i,
  output vcrc_lane_ctl_t       lane_ctl_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 vld_o,
  output logic [CNT_W-1:0]     idx_o
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  vcrc_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic             vs_q;
  logic             vld_q, vld_d;

  logic             vs_rise;
  logic             arm_req, stop_req;
  logic             close_frm, start_frm;
  logic             last_frm;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_en, tgt_en;

  always_comb begin
    arm_req   = ctl_wr_i & ctl_en_i;
    stop_req  = ctl_wr_i & ~ctl_en_i;
    vs_rise   = vsync_i & ~vs_q;
    cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    last_frm  = (cnt_inc == {1'b0, tgt_q});
    close_frm = !ctl_wr_i && vs_rise && (state_q == S_RUN);
    start_frm = !ctl_wr_i && vs_rise &&
                ((state_q == S_ARM) || (state_q == S_RUN));
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    vld_d   = close_frm;
    if (arm_req) begin
      state_d = S_ARM;
      cnt_d   = CNT_ZERO;
      tgt_d   = (ctl_frames_i == CNT_ZERO) ? CNT_ONE : ctl_frames_i;
    end else if (stop_req) begin
      state_d = S_IDLE;
    end else begin
      unique case (state_q)
        S_ARM: begin
          if (vs_rise) state_d = S_RUN;
        end
        S_RUN: begin
          if (vs_rise) begin
            cnt_d = cnt_inc[CNT_W-1:0];
            if (last_frm) state_d = S_DONE;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_comb begin
    cnt_en = arm_req | close_frm;
    tgt_en = arm_req;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      vs_q    <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vs_q    <= vsync_i;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= CNT_ONE;
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  always_comb begin
    lane_ctl_o.clear = arm_req;
    lane_ctl_o.start = start_frm;
    lane_ctl_o.open  = (state_q == S_RUN);
    lane_ctl_o.close = close_frm;
    lane_ctl_o.first = (cnt_q == CNT_ZERO);
    busy_o           = (state_q == S_ARM) || (state_q == S_RUN);
    done_o           = (state_q == S_DONE);
    vld_o            = vld_q;
    idx_o            = cnt_q;
  end
endmodule

// File: rtl/vcrc_lane.sv
module vcrc_lane
  import vcrc_pkg::*;
#(
  parameter int               PIX_W = 8,
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             de_i,
  input  vcrc_lane_ctl_t   ctl_i,
  output logic [CRC_W-1:0] sum_o,
  output logic             mism_o
);
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c_in,
                                                 input logic [PIX_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = PIX_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] sum_q;
  logic [CRC_W-1:0] ref_q;
  logic             mism_q, mism_d;
  logic             crc_en, sum_en, ref_en, mism_en;
  logic             differs;

  always_comb begin
    differs = (crc_q != ref_q);
    crc_en  = ctl_i.start | (ctl_i.open & de_i);
    crc_d   = ctl_i.start ? INIT : crc_fold(crc_q, pix_i);
    sum_en  = ctl_i.close;
    ref_en  = ctl_i.close & ctl_i.first;
    mism_en = ctl_i.clear | (ctl_i.close & ~ctl_i.first & differs);
    mism_d  = ~ctl_i.clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= crc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (ref_en) begin
      ref_q <= crc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mism_q <= 1'b0;
    end else if (mism_en) begin
      mism_q <= mism_d;
    end
  end

  assign sum_o  = sum_q;
  assign mism_o = mism_q;
endmodule

// File: rtl/vcrc_frame_checker.sv
module vcrc_frame_checker
  import vcrc_pkg::*;
#(
  parameter int               PIX_W = 8,
  parameter int               CRC_W = 16,
  parameter int               CNT_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021,
  parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_i,
  input  logic             de_i,
  input  logic [PIX_W-1:0] pix_r_i,
  input  logic [PIX_W-1:0] pix_g_i,
  input  logic [PIX_W-1:0] pix_b_i,
  input  logic             ctl_wr_i,
  input  logic             ctl_en_i,
  input  logic [CNT_W-1:0] ctl_frames_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             frm_vld_o,
  output logic [CNT_W-1:0] frm_idx_o,
  output logic [CRC_W-1:0] crc_r_o,
  output logic [CRC_W-1:0] crc_g_o,
  output logic [CRC_W-1:0] crc_b_o,
  output logic [2:0]       mism_o
);
  localparam int NCH = 3;

  logic             srst_n;
  vcrc_lane_ctl_t   lane_ctl;
  logic [PIX_W-1:0] pix_ch [NCH];
  logic [CRC_W-1:0] sum_ch [NCH];
  logic [NCH-1:0]   mism_ch;

  vcrc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  vcrc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (srst_n),
    .vsync_i      (vsync_i),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_en_i     (ctl_en_i),
    .ctl_frames_i (ctl_frames_i),
    .lane_ctl_o   (lane_ctl),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .vld_o        (frm_vld_o),
    .idx_o        (frm_idx_o)
  );

  always_comb begin
    pix_ch[0] = pix_r_i;
    pix_ch[1] = pix_g_i;
    pix_ch[2] = pix_b_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    vcrc_lane #(
      .PIX_W (PIX_W),
      .CRC_W (CRC_W),
      .POLY  (POLY),
      .INIT  (INIT)
    ) u_lane (
      .clk    (clk),
      .rst_n  (srst_n),
      .pix_i  (pix_ch[c]),
      .de_i   (de_i),
      .ctl_i  (lane_ctl),
      .sum_o  (sum_ch[c]),
      .mism_o (mism_ch[c])
    );
  end

  assign crc_r_o = sum_ch[0];
  assign crc_g_o = sum_ch[1];
  assign crc_b_o = sum_ch[2];
  assign mism_o  = mism_ch;
endmodule

// File: rtl/vcrc_frame_checker_chk.sv
module vcrc_frame_checker_chk #(
  parameter int PIX_W = 8,
  parameter int CRC_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync_i,
  input logic             de_i,
  input logic [PIX_W-1:0] pix_r_i,
  input logic [PIX_W-1:0] pix_g_i,
  input logic [PIX_W-1:0] pix_b_i,
  input logic             ctl_wr_i,
  input logic             ctl_en_i,
  input logic [CNT_W-1:0] ctl_frames_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             frm_vld_o,
  input logic [CNT_W-1:0] frm_idx_o,
  input logic [CRC_W-1:0] crc_r_o,
  input logic [CRC_W-1:0] crc_g_o,
  input logic [CRC_W-1:0] crc_b_o,
  input logic [2:0]       mism_o
);
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && ctl_en_i) |=> (!done_o && busy_o && mism_o == 3'b000 && frm_idx_o == '0));

  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && !ctl_en_i) |=> (!busy_o && !done_o));

  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ctl_wr_i) |=> (done_o && !frm_vld_o && $stable(crc_r_o) &&
                               $stable(crc_g_o) && $stable(crc_b_o) && $stable(mism_o)));

  a_r4_vld_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld_o |-> ($past(busy_o) && $past(vsync_i)));

  a_r4_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld_o |-> (frm_idx_o == CNT_W'($past(frm_idx_o) + 1'b1)));

  a_r5_mism_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_wr_i) |-> ((mism_o & $past(mism_o)) == $past(mism_o)));

  a_r2_sums_move_on_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld_o |-> ($stable(crc_r_o) && $stable(crc_g_o) && $stable(crc_b_o)));

  a_r10_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
endmodule

bind vcrc_frame_checker vcrc_frame_checker_chk #(
  .PIX_W (PIX_W),
  .CRC_W (CRC_W),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/vcrc_frame_checker_tb_top.sv
module vcrc_frame_checker_tb_top;
  localparam int LINES = 4;
  localparam int COLS  = 16;

  logic        clk;
  logic        rst_n;
  logic        vsync_i;
  logic        de_i;
  logic [7:0]  pix_r_i, pix_g_i, pix_b_i;
  logic        ctl_wr_i, ctl_en_i;
  logic [7:0]  ctl_frames_i;
  logic        busy_o, done_o, frm_vld_o;
  logic [7:0]  frm_idx_o;
  logic [15:0] crc_r_o, crc_g_o, crc_b_o;
  logic [2:0]  mism_o;

  int checks;
  int errors;
  int cycles;
  int vld_cnt;
  logic [15:0] rec [3][256];

  vcrc_frame_checker dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync_i      (vsync_i),
    .de_i         (de_i),
    .pix_r_i      (pix_r_i),
    .pix_g_i      (pix_g_i),
    .pix_b_i      (pix_b_i),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_en_i     (ctl_en_i),
    .ctl_frames_i (ctl_frames_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .frm_vld_o    (frm_vld_o),
    .frm_idx_o    (frm_idx_o),
    .crc_r_o      (crc_r_o),
    .crc_g_o      (crc_g_o),
    .crc_b_o      (crc_b_o),
    .mism_o       (mism_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, act cycles=%0d exp below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // capture every per-frame result, away from the active edge
  always @(negedge clk) begin
    if (frm_vld_o) begin
      rec[0][frm_idx_o] = crc_r_o;
      rec[1][frm_idx_o] = crc_g_o;
      rec[2][frm_idx_o] = crc_b_o;
      vld_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pixval(int seed, int ch, int ln, int col);
    return 8'((seed * 29) + (ch * 71) + (ln * 17) + (col * 5) + (ln * col));
  endfunction

  // bit-serial reference over one frame; flip_ch < 0 means no flipped pixel
  function automatic logic [15:0] model(int seed, int ch, int flip_ch, int flip_pos);
    logic [15:0] c;
    logic [7:0]  p;
    logic        fb;
    c = 16'hFFFF;
    for (int ln = 0; ln < LINES; ln++) begin
      for (int col = 0; col < COLS; col++) begin
        p = pixval(seed, ch, ln, col);
        if (ch == flip_ch && (ln * COLS + col) == flip_pos) p = p ^ 8'h10;
        for (int b = 7; b >= 0; b--) begin
          fb = c[15] ^ p[b];
          c  = {c[14:0], 1'b0};
          if (fb) c = c ^ 16'h1021;
        end
      end
    end
    return c;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_vsync();
    @(negedge clk);
    vsync_i = 1'b1;
    idle(2);
    vsync_i = 1'b0;
    idle(3);
  endtask

  task automatic send_frame(int seed, int flip_ch, int flip_pos);
    send_vsync();
    for (int ln = 0; ln < LINES; ln++) begin
      for (int col = 0; col < COLS; col++) begin
        de_i    = 1'b1;
        pix_r_i = pixval(seed, 0, ln, col);
        pix_g_i = pixval(seed, 1, ln, col);
        pix_b_i = pixval(seed, 2, ln, col);
        if ((ln * COLS + col) == flip_pos) begin
          if (flip_ch == 0) pix_r_i = pix_r_i ^ 8'h10;
          if (flip_ch == 1) pix_g_i = pix_g_i ^ 8'h10;
          if (flip_ch == 2) pix_b_i = pix_b_i ^ 8'h10;
        end
        @(negedge clk);
      end
      de_i    = 1'b0;
      pix_r_i = 8'hA5;
      pix_g_i = 8'h5A;
      pix_b_i = 8'h3C;
      idle(4);
    end
  endtask

  task automatic ctl_write(logic en, logic [7:0] frames);
    @(negedge clk);
    ctl_wr_i     = 1'b1;
    ctl_en_i     = en;
    ctl_frames_i = frames;
    @(negedge clk);
    ctl_wr_i     = 1'b0;
    ctl_en_i     = 1'b0;
    ctl_frames_i = 8'h00;
  endtask

  task automatic t_reset();
    check("R10 busy after reset", 32'(busy_o), 32'd0);
    check("R10 done after reset", 32'(done_o), 32'd0);
    check("R10 vld after reset", 32'(frm_vld_o), 32'd0);
    check("R10 mism after reset", 32'(mism_o), 32'd0);
    check("R10 idx after reset", 32'(frm_idx_o), 32'd0);
    check("R10 crc after reset", {crc_r_o, crc_g_o ^ crc_b_o}, 32'd0);
  endtask

  task automatic t_static();
    vld_cnt = 0;
    ctl_write(1'b1, 8'd3);
    for (int f = 0; f < 3; f++) send_frame(7, -1, 0);
    send_vsync();
    idle(3);
    check("R4 three frame pulses", 32'(vld_cnt), 32'd3);
    check("R4 done after three", 32'(done_o), 32'd1);
    check("R4 index three", 32'(frm_idx_o), 32'd3);
    for (int f = 1; f <= 3; f++) begin
      check("R1 red checksum", 32'(rec[0][f]), 32'(model(7, 0, -1, 0)));
      check("R2 green checksum", 32'(rec[1][f]), 32'(model(7, 1, -1, 0)));
      check("R2 blue checksum", 32'(rec[2][f]), 32'(model(7, 2, -1, 0)));
    end
    check("R5 static no mismatch", 32'(mism_o), 32'd0);
  endtask

  task automatic t_partial();
    vld_cnt = 0;
    ctl_write(1'b1, 8'd2);
    for (int i = 0; i < 20; i++) begin
      de_i    = 1'b1;
      pix_r_i = 8'(i * 3);
      pix_g_i = 8'(i * 11);
      pix_b_i = 8'(i + 99);
      @(negedge clk);
    end
    de_i = 1'b0;
    idle(3);
    check("R3 still armed", 32'(busy_o), 32'd1);
    send_frame(12, -1, 0);
    send_frame(12, -1, 0);
    send_vsync();
    idle(3);
    check("R3 pulses", 32'(vld_cnt), 32'd2);
    check("R3 first frame red", 32'(rec[0][1]), 32'(model(12, 0, -1, 0)));
    check("R3 first frame blue", 32'(rec[2][1]), 32'(model(12, 2, -1, 0)));
    check("R3 no mismatch", 32'(mism_o), 32'd0);
  endtask

  task automatic t_flip();
    vld_cnt = 0;
    ctl_write(1'b1, 8'd3);
    send_frame(21, -1, 0);
    send_frame(21, 1, 39);
    send_frame(21, -1, 0);
    send_vsync();
    idle(3);
    check("R6 flipped green", 32'(rec[1][2]), 32'(model(21, 1, 1, 39)));
    check("R6 green differs", 32'(rec[1][2] != rec[1][1]), 32'd1);
    check("R6 red unaffected", 32'(rec[0][2]), 32'(model(21, 0, -1, 0)));
    check("R6 blue unaffected", 32'(rec[2][2]), 32'(model(21, 2, -1, 0)));
    check("R5 sticky green mismatch", 32'(mism_o), 32'b010);
    check("R5 done", 32'(done_o), 32'd1);
  endtask

  task automatic t_hold();
    logic [15:0] r, g, b;
    r = crc_r_o;
    g = crc_g_o;
    b = crc_b_o;
    vld_cnt = 0;
    send_frame(50, -1, 0);
    send_frame(51, 0, 3);
    send_vsync();
    idle(3);
    check("R9 no pulses after done", 32'(vld_cnt), 32'd0);
    check("R9 sums held", {r ^ crc_r_o, (g ^ crc_g_o) | (b ^ crc_b_o)}, 32'd0);
    check("R9 mismatch held", 32'(mism_o), 32'b010);
    check("R9 done held", 32'(done_o), 32'd1);
  endtask

  task automatic t_restart();
    ctl_write(1'b1, 8'd1);
    check("R7 done cleared", 32'(done_o), 32'd0);
    check("R7 mismatch cleared", 32'(mism_o), 32'd0);
    check("R7 busy", 32'(busy_o), 32'd1);
    check("R7 index cleared", 32'(frm_idx_o), 32'd0);
  endtask

  task automatic t_zero();
    vld_cnt = 0;
    ctl_write(1'b1, 8'd0);
    send_frame(33, -1, 0);
    send_vsync();
    send_frame(34, -1, 0);
    send_vsync();
    idle(3);
    check("R4 zero runs one frame", 32'(vld_cnt), 32'd1);
    check("R4 zero done", 32'(done_o), 32'd1);
    check("R4 zero checksum", 32'(crc_g_o), 32'(model(33, 1, -1, 0)));
  endtask

  task automatic t_stop();
    vld_cnt = 0;
    ctl_write(1'b1, 8'd5);
    send_frame(40, -1, 0);
    send_frame(40, -1, 0);
    ctl_write(1'b0, 8'd0);
    check("R8 idle after abort", 32'(busy_o), 32'd0);
    send_frame(40, -1, 0);
    send_frame(41, -1, 0);
    send_vsync();
    idle(3);
    check("R8 no further pulses", 32'(vld_cnt), 32'd1);
    check("R8 not done", 32'(done_o), 32'd0);
  endtask

  task automatic t_max();
    vld_cnt = 0;
    ctl_write(1'b1, 8'd255);
    for (int f = 0; f < 255; f++) send_frame(3, -1, 0);
    send_vsync();
    idle(3);
    check("R4 max pulses", 32'(vld_cnt), 32'd255);
    check("R4 max index", 32'(frm_idx_o), 32'd255);
    check("R4 max done", 32'(done_o), 32'd1);
    check("R5 max no mismatch", 32'(mism_o), 32'd0);
    check("R1 max last red", 32'(rec[0][255]), 32'(model(3, 0, -1, 0)));
  endtask

  initial begin
    checks       = 0;
    errors       = 0;
    cycles       = 0;
    vld_cnt      = 0;
    rst_n        = 1'b0;
    vsync_i      = 1'b0;
    de_i         = 1'b0;
    pix_r_i      = 8'h00;
    pix_g_i      = 8'h00;
    pix_b_i      = 8'h00;
    ctl_wr_i     = 1'b0;
    ctl_en_i     = 1'b0;
    ctl_frames_i = 8'h00;
    idle(4);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_static();
    t_partial();
    t_flip();
    t_hold();
    t_restart();
    t_zero();
    t_stop();
    t_max();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule